// File: doc/BRIEF.md
# Dual-Strobe Page-Mode DRAM Cycle Decoder

This block is a synthesizable behavioural model of the control side of an asynchronous page-mode DRAM. The DRAM has a 16-bit data path, a multiplexed 10-bit address and two column strobes, one for each byte lane. A fast oversampling clock samples the active-low strobes (row strobe, lower and upper column strobes, write enable, output enable). From them the block classifies each memory cycle: standby, row-only refresh, read, write, counter-driven refresh with the column strobe leading, or hidden refresh. It drives one output-enable bit per byte lane, next to the read data, so that a surrounding pad ring or testbench can build the tristate bus.

A small storage array holds the written data so that reads can be checked against earlier writes. The array index is formed by folding the latched row and column addresses. An internal refresh row pointer advances on every counter-driven refresh and is visible at a port. All results are registered, so each one appears one oversampling clock after the inputs that cause it have been sampled.

Top module: `dual_cas_dram_model`

## Requirements
- R1: After reset the cycle class is standby (code 0), both lane enables are 0 and the refresh pointer is 0.
- R2: When the row strobe falls while both column strobes are high, the row address is latched. Until a column strobe falls, the class is row-only refresh (code 1) and no lane is driven. After the return to idle the class goes back to standby.
- R3: A word write (both column strobes low, write enable low) stores the data input at the latched row and column, and the class is write (code 3). A later word read at the same address returns that data with both lane enables set and class read (code 2).
- R4: The lower column strobe governs bits 7:0 and lane enable bit 0; the upper one governs bits 15:8 and lane enable bit 1. A lane whose strobe is high is neither written nor driven, and its data output bits read 0.
- R5: A write takes the data present at the later of the column-strobe fall and the write-enable fall. A change of the data input afterwards, within the same strobe cycle, is not stored.
- R6: A lane is driven only while write enable is high, output enable is low and that lane's strobe is low. Driving starts with whichever of the strobe fall and the output-enable fall comes later.
- R7: The column address is latched when the first column strobe falls. A second strobe falling later does not change the column, and the access continues until the last strobe returns high.
- R8: While the row strobe stays low, each new column-strobe cycle latches a new column in the same open row (page mode). Between these cycles the class is row-only (code 1).
- R9: If the row strobe falls while a column strobe is already low, the class is counter refresh (code 4). No lane is driven, the address and write inputs do not touch storage, and the refresh pointer advances by one, wrapping to 0 after REF_ROWS-1.
- R10: After a read, if the column strobes stay low while the row strobe rises and falls again, the class becomes hidden refresh (code 5). The read data stays driven and unchanged, and the refresh pointer advances.
- R11: After any cycle, a new cycle starts only once the row strobe and both column strobes have been high together. A row-strobe fall before that point leaves the class at standby and the pointer unchanged.
- R12: Addresses below 8 map directly to distinct storage words (row and column index bits 2:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (10) | Multiplexed row/column address |
| din | input | DATA_W (16) | Write data |
| dout | output | DATA_W (16) | Read data, zero on undriven lanes |
| lane_oe | output | 2 | Per-lane drive enable, bit 0 lower byte |
| cyc_class | output | 3 | Cycle class code |
| ref_ptr | output | REF_W (3) | Next row of the internal refresh pointer |

## Verification
The class, lane enables, read data and refresh pointer all come from one register stage. Each is therefore due exactly one clock after the strobe pattern that causes it has been sampled. The bench changes inputs on the falling clock edge, then waits one full rising edge and reads the outputs at the next falling edge, so every check falls in the cycle where the result is due. Multi-step sequences check their intermediate states: hold, hidden refresh, page gap and the post-refresh wait. These are checked one cycle apart, and storage effects are confirmed by a later, separate read.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

   typedef enum logic [2:0] {
      CLS_STANDBY  = 3'd0,
      CLS_RAS_ONLY = 3'd1,
      CLS_READ     = 3'd2,
      CLS_WRITE    = 3'd3,
      CLS_CBR      = 3'd4,
      CLS_HIDDEN   = 3'd5
   } cyc_class_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_ACC,
      ST_HOLD,
      ST_HID,
      ST_CBR,
      ST_WAIT
   } ctl_state_e;

endpackage

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
   parameter int REF_ROWS = 8,
   localparam int REF_W   = (REF_ROWS > 1) ? $clog2(REF_ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   output logic [REF_W-1:0] ptr
);

   logic [REF_W-1:0] ptr_q;
   logic [REF_W-1:0] ptr_inc;

   generate
      if ((1 << REF_W) == REF_ROWS) begin : g_pow2
         assign ptr_inc = ptr_q + 1'b1;
      end else begin : g_mod
         assign ptr_inc = (ptr_q == REF_W'(REF_ROWS - 1)) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q <= '0;
      else if (fire) ptr_q <= ptr_inc;
   end

   assign ptr = ptr_q;

endmodule

// File: rtl/dcd_cycle_fsm.sv
module dcd_cycle_fsm
   import dcd_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int ROW_IDX_W = 3,
   parameter int COL_IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ras_n,
   input  logic [1:0]           cas_n,
   input  logic                 we_n,
   input  logic [ADDR_W-1:0]    addr,
   output ctl_state_e           st_nxt,
   output logic [ROW_IDX_W-1:0] row_nxt,
   output logic [COL_IDX_W-1:0] col_nxt,
   output logic                 ref_fire,
   output cyc_class_e           cls
);

   ctl_state_e           st_q;
   cyc_class_e           cls_q, cls_d;
   logic [ROW_IDX_W-1:0] row_q, row_fold;
   logic [COL_IDX_W-1:0] col_q, col_fold;
   logic                 cas_any, cas_none;

   assign cas_none = &cas_n;
   assign cas_any  = ~cas_none;

   // fold every address bit into the narrow storage index
   always_comb begin
      row_fold = '0;
      col_fold = '0;
      for (int i = 0; i < ADDR_W; i++) begin
         row_fold[i % ROW_IDX_W] ^= addr[i];
         col_fold[i % COL_IDX_W] ^= addr[i];
      end
   end

   always_comb begin
      st_nxt   = st_q;
      row_nxt  = row_q;
      col_nxt  = col_q;
      ref_fire = 1'b0;
      unique case (st_q)
         ST_IDLE:
            if (!ras_n) begin
               if (cas_any) begin
                  st_nxt   = ST_CBR;
                  ref_fire = 1'b1;
               end else begin
                  st_nxt  = ST_ROW;
                  row_nxt = row_fold;
               end
            end
         ST_ROW:
            if (ras_n)        st_nxt = cas_none ? ST_IDLE : ST_WAIT;
            else if (cas_any) begin
               st_nxt  = ST_ACC;
               col_nxt = col_fold;
            end
         ST_ACC:
            if (ras_n)         st_nxt = cas_none ? ST_IDLE : ST_HOLD;
            else if (cas_none) st_nxt = ST_ROW;
         ST_HOLD:
            if (cas_none)      st_nxt = ras_n ? ST_IDLE : ST_WAIT;
            else if (!ras_n) begin
               st_nxt   = ST_HID;
               ref_fire = 1'b1;
            end
         ST_HID:
            if (cas_none)      st_nxt = ras_n ? ST_IDLE : ST_WAIT;
            else if (ras_n)    st_nxt = ST_HOLD;
         ST_CBR:
            if (ras_n)         st_nxt = cas_none ? ST_IDLE : ST_WAIT;
         ST_WAIT:
            if (ras_n && cas_none) st_nxt = ST_IDLE;
         default:              st_nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (st_nxt)
         ST_ROW:  cls_d = CLS_RAS_ONLY;
         ST_ACC:  cls_d = we_n ? CLS_READ : CLS_WRITE;
         ST_HOLD: cls_d = cls_q;
         ST_HID:  cls_d = CLS_HIDDEN;
         ST_CBR:  cls_d = CLS_CBR;
         default: cls_d = CLS_STANDBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cls_q <= CLS_STANDBY;
         row_q <= '0;
         col_q <= '0;
      end else begin
         st_q  <= st_nxt;
         cls_q <= cls_d;
         row_q <= row_nxt;
         col_q <= col_nxt;
      end
   end

   assign cls = cls_q;

endmodule

// File: rtl/dcd_lane_store.sv
module dcd_lane_store #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   parameter int IDX_W  = 6,
   localparam int LANES = DATA_W / LANE_W,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_nxt,
   input  logic              drive_nxt,
   input  logic [LANES-1:0]  cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic [LANES-1:0]  lane_oe
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] data_q;
      logic              oe_q, wr_done, wr_go, drive_d;

      // one capture per strobe/write-enable overlap
      assign wr_go   = acc_nxt & ~we_n & ~cas_n[g] & ~wr_done;
      assign drive_d = drive_nxt & we_n & ~oe_n & ~cas_n[g];

      always_ff @(posedge clk) begin
         if (wr_go) mem[idx] <= din[g*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_done <= 1'b0;
            oe_q    <= 1'b0;
            data_q  <= '0;
         end else begin
            wr_done <= acc_nxt & ~we_n & ~cas_n[g] & (wr_done | wr_go);
            oe_q    <= drive_d;
            data_q  <= drive_d ? mem[idx] : '0;
         end
      end

      assign lane_oe[g]                  = oe_q;
      assign dout[g*LANE_W +: LANE_W]    = data_q;
   end

endmodule

// File: rtl/dual_cas_dram_model.sv
module dual_cas_dram_model
   import dcd_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 16,
   parameter int LANE_W    = 8,
   parameter int ROW_IDX_W = 3,
   parameter int COL_IDX_W = 3,
   parameter int REF_ROWS  = 8,
   localparam int LANES    = DATA_W / LANE_W,
   localparam int IDX_W    = ROW_IDX_W + COL_IDX_W,
   localparam int REF_W    = (REF_ROWS > 1) ? $clog2(REF_ROWS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              lcas_n,
   input  logic              ucas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic [1:0]        lane_oe,
   output logic [2:0]        cyc_class,
   output logic [REF_W-1:0]  ref_ptr
);

   if (LANES != 2 || LANES * LANE_W != DATA_W) begin : g_bad_lanes
      $error("dual_cas_dram_model: DATA_W must be exactly two lanes of LANE_W");
   end
   if (ROW_IDX_W < 1 || ROW_IDX_W > ADDR_W || COL_IDX_W < 1 || COL_IDX_W > ADDR_W) begin : g_bad_idx
      $error("dual_cas_dram_model: index widths must lie in 1..ADDR_W");
   end
   if (IDX_W > 12) begin : g_bad_depth
      $error("dual_cas_dram_model: storage index too wide for a model array");
   end
   if (REF_ROWS < 2) begin : g_bad_ref
      $error("dual_cas_dram_model: REF_ROWS must be at least 2");
   end

   ctl_state_e           st_nxt;
   cyc_class_e           cls;
   logic [ROW_IDX_W-1:0] row_nxt;
   logic [COL_IDX_W-1:0] col_nxt;
   logic                 ref_fire;
   logic [1:0]           cas_n;
   logic                 acc_nxt, drive_nxt;

   assign cas_n     = {ucas_n, lcas_n};
   assign acc_nxt   = (st_nxt == ST_ACC);
   assign drive_nxt = (st_nxt == ST_ACC) || (st_nxt == ST_HOLD) || (st_nxt == ST_HID);

   dcd_cycle_fsm #(
      .ADDR_W    (ADDR_W),
      .ROW_IDX_W (ROW_IDX_W),
      .COL_IDX_W (COL_IDX_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .addr     (addr),
      .st_nxt   (st_nxt),
      .row_nxt  (row_nxt),
      .col_nxt  (col_nxt),
      .ref_fire (ref_fire),
      .cls      (cls)
   );

   dcd_lane_store #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W),
      .IDX_W  (IDX_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_nxt   (acc_nxt),
      .drive_nxt (drive_nxt),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .oe_n      (oe_n),
      .idx       ({row_nxt, col_nxt}),
      .din       (din),
      .dout      (dout),
      .lane_oe   (lane_oe)
   );

   dcd_refresh_ctr #(
      .REF_ROWS (REF_ROWS)
   ) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (ref_fire),
      .ptr   (ref_ptr)
   );

   assign cyc_class = cls;

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
   parameter int DATA_W = 16,
   parameter int REF_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lcas_n,
   input logic              ucas_n,
   input logic              we_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] dout,
   input logic [1:0]        lane_oe,
   input logic [2:0]        cyc_class,
   input logic [REF_W-1:0]  ref_ptr
);

   assert_ras_only_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_class == 3'd1) |-> (lane_oe == 2'b00));

   assert_lower_lane_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_oe[0] |-> $past(!lcas_n));

   assert_upper_lane_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_oe[1] |-> $past(!ucas_n));

   assert_read_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_oe) |-> $past(!oe_n && we_n));

   assert_cbr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_class == 3'd4) |-> (lane_oe == 2'b00));

   assert_ref_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_ptr != $past(ref_ptr)) |-> (cyc_class == 3'd4 || cyc_class == 3'd5));

   assert_hidden_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_class == 3'd5 && $past(cyc_class) == 3'd5) |-> $stable(dout));

endmodule

bind dual_cas_dram_model dcd_checker #(
   .DATA_W (DATA_W),
   .REF_W  (REF_W)
) u_dcd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .lcas_n    (lcas_n),
   .ucas_n    (ucas_n),
   .we_n      (we_n),
   .oe_n      (oe_n),
   .dout      (dout),
   .lane_oe   (lane_oe),
   .cyc_class (cyc_class),
   .ref_ptr   (ref_ptr)
);

// File: tb/dual_cas_dram_model_bench.sv
module dual_cas_dram_model_bench;

   localparam int CLK_PERIOD = 10;
   localparam int REF_ROWS   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [9:0]  addr = '0;
   logic [15:0] din = '0;
   logic [15:0] dout;
   logic [1:0]  lane_oe;
   logic [2:0]  cyc_class;
   logic [2:0]  ref_ptr;

   int n_chk = 0;
   int n_bad = 0;
   logic [2:0] exp_ptr = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_cas_dram_model u_dual_cas_dram_model (
      .clk (clk), .rst_n (rst_n), .ras_n (ras_n), .lcas_n (lcas_n), .ucas_n (ucas_n),
      .we_n (we_n), .oe_n (oe_n), .addr (addr), .din (din), .dout (dout),
      .lane_oe (lane_oe), .cyc_class (cyc_class), .ref_ptr (ref_ptr)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic go_idle();
      ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      tick();
   endtask

   task automatic write_at(input logic [9:0] row, input logic [9:0] col,
                           input logic [15:0] data, input logic [1:0] lanes);
      ras_n = 1'b0; addr = row; tick();
      addr = col; din = data; we_n = 1'b0;
      lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; tick();
      go_idle();
   endtask

   task automatic read_at(input logic [9:0] row, input logic [9:0] col,
                          input logic [1:0] lanes,
                          output logic [15:0] rd, output logic [1:0] oe);
      ras_n = 1'b0; addr = row; tick();
      addr = col; oe_n = 1'b0; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; tick();
      rd = dout; oe = lane_oe;
      go_idle();
   endtask

   task automatic t_reset();
      check("R1", "class", 32'(cyc_class), 32'd0);
      check("R1", "lane_oe", 32'(lane_oe), 32'd0);
      check("R1", "ref_ptr", 32'(ref_ptr), 32'd0);
   endtask

   task automatic t_ras_only();
      ras_n = 1'b0; addr = 10'd5; tick();
      check("R2", "class open row", 32'(cyc_class), 32'd1);
      check("R2", "lane_oe open row", 32'(lane_oe), 32'd0);
      go_idle();
      check("R2", "class after idle", 32'(cyc_class), 32'd0);
   endtask

   task automatic t_word();
      logic [15:0] rd; logic [1:0] oe;
      ras_n = 1'b0; addr = 10'd2; tick();
      addr = 10'd4; din = 16'hA5C3; we_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; tick();
      check("R3", "class write", 32'(cyc_class), 32'd3);
      go_idle();
      read_at(10'd2, 10'd4, 2'b11, rd, oe);
      check("R3", "word read data", 32'(rd), 32'hA5C3);
      check("R3", "word read lanes", 32'(oe), 32'd3);
   endtask

   task automatic t_byte();
      logic [15:0] rd; logic [1:0] oe;
      write_at(10'd1, 10'd1, 16'h1111, 2'b11);
      write_at(10'd1, 10'd1, 16'hABAB, 2'b01);
      read_at(10'd1, 10'd1, 2'b11, rd, oe);
      check("R4", "upper lane kept", 32'(rd), 32'h11AB);
      read_at(10'd1, 10'd1, 2'b01, rd, oe);
      check("R4", "lower-only data", 32'(rd), 32'h00AB);
      check("R4", "lower-only lanes", 32'(oe), 32'd1);
      read_at(10'd1, 10'd1, 2'b10, rd, oe);
      check("R4", "upper-only data", 32'(rd), 32'h1100);
      check("R4", "upper-only lanes", 32'(oe), 32'd2);
   endtask

   task automatic t_late_write();
      logic [15:0] rd; logic [1:0] oe;
      ras_n = 1'b0; addr = 10'd3; tick();
      addr = 10'd2; lcas_n = 1'b0; ucas_n = 1'b0; tick();
      check("R6", "no drive with oe high", 32'(lane_oe), 32'd0);
      check("R5", "class before we", 32'(cyc_class), 32'd2);
      din = 16'hBEEF; we_n = 1'b0; tick();
      check("R5", "class at late we", 32'(cyc_class), 32'd3);
      din = 16'hDEAD; tick();
      go_idle();
      read_at(10'd3, 10'd2, 2'b11, rd, oe);
      check("R5", "data at later fall", 32'(rd), 32'hBEEF);
   endtask

   task automatic t_oe();
      ras_n = 1'b0; addr = 10'd2; tick();
      addr = 10'd4; lcas_n = 1'b0; ucas_n = 1'b0; tick();
      check("R6", "strobe only", 32'(lane_oe), 32'd0);
      oe_n = 1'b0; tick();
      check("R6", "after oe fall lanes", 32'(lane_oe), 32'd3);
      check("R6", "after oe fall data", 32'(dout), 32'hA5C3);
      go_idle();
   endtask

   task automatic t_first_cas();
      write_at(10'd3, 10'd5, 16'h5555, 2'b11);
      ras_n = 1'b0; addr = 10'd3; tick();
      addr = 10'd2; oe_n = 1'b0; lcas_n = 1'b0; tick();
      check("R7", "first lane data", 32'(dout), 32'h00EF);
      addr = 10'd5; ucas_n = 1'b0; tick();
      check("R7", "column from first fall", 32'(dout), 32'hBEEF);
      lcas_n = 1'b1; tick();
      check("R7", "access holds lanes", 32'(lane_oe), 32'd2);
      check("R7", "access holds class", 32'(cyc_class), 32'd2);
      go_idle();
   endtask

   task automatic t_page();
      ras_n = 1'b0; addr = 10'd4; tick();
      addr = 10'd0; din = 16'h0101; we_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; tick();
      lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; tick();
      check("R8", "page gap class", 32'(cyc_class), 32'd1);
      addr = 10'd1; din = 16'h0202; we_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; tick();
      go_idle();
      ras_n = 1'b0; addr = 10'd4; tick();
      addr = 10'd0; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; tick();
      check("R8", "page read col0", 32'(dout), 32'h0101);
      lcas_n = 1'b1; ucas_n = 1'b1; tick();
      check("R8", "page gap lanes", 32'(lane_oe), 32'd0);
      addr = 10'd1; lcas_n = 1'b0; ucas_n = 1'b0; tick();
      check("R8", "page read col1", 32'(dout), 32'h0202);
      go_idle();
   endtask

   task automatic t_hidden();
      ras_n = 1'b0; addr = 10'd3; tick();
      addr = 10'd2; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; tick();
      check("R10", "read before hide", 32'(dout), 32'hBEEF);
      ras_n = 1'b1; tick();
      check("R10", "hold keeps data", 32'(dout), 32'hBEEF);
      ras_n = 1'b0; tick();
      exp_ptr = exp_ptr + 3'd1;
      check("R10", "hidden class", 32'(cyc_class), 32'd5);
      check("R10", "hidden data", 32'(dout), 32'hBEEF);
      check("R10", "hidden lanes", 32'(lane_oe), 32'd3);
      check("R10", "hidden ptr", 32'(ref_ptr), 32'(exp_ptr));
      go_idle();
   endtask

   task automatic t_cbr();
      logic [15:0] rd; logic [1:0] oe;
      lcas_n = 1'b0; tick();
      check("R11", "strobe before row is standby", 32'(cyc_class), 32'd0);
      ras_n = 1'b0; addr = 10'd3; we_n = 1'b0; din = 16'h0000; oe_n = 1'b0; tick();
      exp_ptr = exp_ptr + 3'd1;
      check("R9", "cbr class", 32'(cyc_class), 32'd4);
      check("R9", "cbr lanes", 32'(lane_oe), 32'd0);
      check("R9", "cbr ptr", 32'(ref_ptr), 32'(exp_ptr));
      ras_n = 1'b1; tick();
      ras_n = 1'b0; tick();
      check("R11", "no cycle before idle", 32'(cyc_class), 32'd0);
      check("R11", "ptr unchanged", 32'(ref_ptr), 32'(exp_ptr));
      go_idle();
      for (int k = 0; k < REF_ROWS; k++) begin
         lcas_n = 1'b0; ucas_n = 1'b0; tick();
         ras_n = 1'b0; tick();
         go_idle();
      end
      check("R9", "ptr wraps", 32'(ref_ptr), 32'(exp_ptr));
      read_at(10'd3, 10'd2, 2'b11, rd, oe);
      check("R9", "address ignored", 32'(rd), 32'hBEEF);
   endtask

   task automatic t_map();
      logic [15:0] rd; logic [1:0] oe;
      write_at(10'd7, 10'd6, 16'h7766, 2'b11);
      write_at(10'd6, 10'd7, 16'h6677, 2'b11);
      read_at(10'd7, 10'd6, 2'b11, rd, oe);
      check("R12", "distinct words", 32'(rd), 32'h7766);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_ras_only();
      t_word();
      t_byte();
      t_late_write();
      t_oe();
      t_first_cas();
      t_page();
      t_hidden();
      t_cbr();
      t_map();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule